// File: doc/BRIEF.md
# Special-Cycle Bus Disconnect Controller

This block lives inside a system-bus controller. It watches the special cycles that a processor issues and decides when to ask the bus to disconnect. Only a stop-grant special cycle can start a disconnect, and only while the enable bit of the timing/control byte is set. A halt special cycle never starts one, whatever the configuration says. After a disconnect, the bus stays disconnected until a wake event arrives. The block then raises a reconnect request for exactly one cycle and returns to the connected state.

The control byte is read and written through a simple register port. Its upper bit is the disconnect enable. The other bits are timing fields that this block stores but does not interpret. The byte survives a suspend indication, and only the synchronous reset restores it. A low-power flag tells the rest of the chip when real power savings apply. That is the case only when the processor has been put into stop grant and the bus is also disconnected.

Top module: `spc_disc_top`

## Requirements
- R1: When `spc_valid` is high with `spc_type` = 2'b10 (stop grant), bit 7 of the control byte is 1 and `wake` is low, `disc_req` is high in the following cycle. In the cycle after that, `bus_connected` is low.
- R2: While bit 7 of the control byte is 0, a stop-grant cycle never raises `disc_req` and never lowers `bus_connected`.
- R3: A halt cycle (`spc_type` = 2'b01) never starts a disconnect, even with bit 7 set. Type codes 2'b00 and 2'b11 are ignored.
- R4: Reset loads the control byte with bit 7 = 0, bit 6 = 1, bits 5:4 = 2'b11, bit 3 = `strap_skew_en` as sampled during reset, and bits 2:0 = 0. The values of bit 7 and bits 2:0 are a modelling choice. Reset also leaves the bus connected with no request outstanding.
- R5: A cycle with `cfg_wr` high stores `cfg_wdata` in all 8 bits. `cfg_rdata` shows the stored byte from the next cycle on.
- R6: `suspend_ind` has no effect on the control byte or on the bus state. Only reset changes the byte without a write.
- R7: `stpgnt_active` is set by any stop-grant cycle, even with bit 7 clear, and is cleared by `wake`. `low_power` is high exactly when `stpgnt_active` is high and the bus is disconnected.
- R8: A `wake` while disconnected raises `reconn_req` for exactly one cycle, with `bus_connected` still low. In the cycle after that, `bus_connected` is high.
- R9: Clearing bit 7 while disconnected does not reconnect the bus. Only `wake` ends the disconnected state.
- R10: If `wake` and a stop-grant cycle arrive in the same cycle while connected, wake wins. No disconnect is requested and `stpgnt_active` stays low.
- R11: A `wake` in the cycle where `disc_req` is high cancels the disconnect. The next cycle is connected with `disc_req` low.
- R12: If a write and a stop-grant cycle arrive in the same cycle, the enable used is bit 7 as stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_skew_en | input | 1 | Strap sampled into bit 3 during reset |
| suspend_ind | input | 1 | Suspend indication; register contents are kept |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Current control byte |
| spc_valid | input | 1 | Special-cycle valid strobe |
| spc_type | input | 2 | Special-cycle type: 01 halt, 10 stop grant |
| wake | input | 1 | Wake event (interrupt-class) |
| disc_req | output | 1 | Disconnect request to the bus interface |
| reconn_req | output | 1 | One-cycle reconnect request |
| bus_connected | output | 1 | Bus is not in the disconnected state |
| stpgnt_active | output | 1 | Processor is in stop grant |
| low_power | output | 1 | Stop grant and bus disconnected together |

## Verification
Three pairs of events can land in the same cycle. A wake can coincide with a stop-grant cycle, a wake can arrive in the pending cycle, and a register write that flips the enable can arrive together with a stop-grant cycle. Directed sequences place each pair on one clock edge. The resulting disconnect request, connected flag and stop-grant flag are compared with the priority set in R10, R11 and R12. Random traffic then mixes wakes, writes and all four type codes at rates that make such collisions frequent, and every output is judged each cycle against a bench model written from the requirements.

// File: rtl/spc_disc_pkg.sv
// Package: shared types and constants for the special-cycle disconnect controller.
// Assumes an 8-bit control byte whose top bit is the disconnect enable.
package spc_disc_pkg;
    localparam int CFG_W      = 8;
    localparam int TYPE_W     = 2;
    localparam int EN_BIT     = 7;
    localparam int SKEW_BIT   = 3;

    localparam logic [TYPE_W-1:0] TYPE_HALT   = 2'b01;
    localparam logic [TYPE_W-1:0] TYPE_STPGNT = 2'b10;

    // Reset image without the strap bit; the strap is merged in at reset.
    localparam logic [CFG_W-1:0] CFG_RST_BASE = 8'b0111_0000;

    typedef enum logic [1:0] {
        ST_CONN = 2'd0,
        ST_PEND = 2'd1,
        ST_DISC = 2'd2
    } disc_state_e;
endpackage

// File: rtl/spc_cfg_reg.sv
// Control byte register: written whole through the register port. Reset loads a
// fixed image with the strap merged into the skew bit. A suspend indication never
// touches the contents.
module spc_cfg_reg #(
    parameter int W        = spc_disc_pkg::CFG_W,
    parameter int STRAP_AT = spc_disc_pkg::SKEW_BIT,
    parameter logic [W-1:0] RST_BASE = spc_disc_pkg::CFG_RST_BASE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strap,
    input  logic         suspend_ind,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cfg_q
);
    logic [W-1:0] rst_image;

    // Build the reset image from the fixed part and the strap.
    always_comb begin
        rst_image           = RST_BASE;
        rst_image[STRAP_AT] = strap;
    end

    // Hold, load from a write, or reload the image on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   cfg_q <= rst_image;
        else if (wr)  cfg_q <= wdata;
    end

    a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cfg_q == $past(wdata));
    a_r6_suspend_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && suspend_ind) |=> $stable(cfg_q));
    a_r6_no_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(cfg_q));
endmodule

// File: rtl/spc_decode.sv
// Special-cycle decoder: turns the valid strobe and type code into one-hot
// halt / stop-grant strobes. Unknown codes produce neither.
module spc_decode #(
    parameter int TW = spc_disc_pkg::TYPE_W,
    parameter logic [TW-1:0] HALT_CODE = spc_disc_pkg::TYPE_HALT,
    parameter logic [TW-1:0] STOP_CODE = spc_disc_pkg::TYPE_STPGNT
) (
    input  logic          valid,
    input  logic [TW-1:0] code,
    output logic          is_halt,
    output logic          is_stpgnt
);
    // Match the type code only while the strobe is high.
    always_comb begin
        is_halt   = valid && (code == HALT_CODE);
        is_stpgnt = valid && (code == STOP_CODE);
    end

    always_comb begin
        a_r3_onehot_decode: assert ($onehot0({is_halt, is_stpgnt}));
    end
endmodule

// File: rtl/spc_disc_fsm.sv
// Disconnect state machine: connected -> pending (one request cycle) ->
// disconnected. It leaves the disconnected state only after a one-cycle
// reconnect request that a wake starts. It also tracks the processor stop-grant
// state. A wake takes priority over a stop grant in the same cycle.
module spc_disc_fsm
    import spc_disc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_en,
    input  logic is_halt,
    input  logic is_stpgnt,
    input  logic wake,
    output logic disc_req,
    output logic reconn_req,
    output logic bus_connected,
    output logic stpgnt_active
);
    disc_state_e state_q, state_d;
    logic        reconn_q, reconn_d;
    logic        stp_q, stp_d;

    // Next-state, reconnect and stop-grant tracking logic.
    always_comb begin
        state_d  = state_q;
        reconn_d = 1'b0;
        stp_d    = stp_q;
        if (wake)           stp_d = 1'b0;
        else if (is_stpgnt) stp_d = 1'b1;
        unique case (state_q)
            ST_CONN: if (is_stpgnt && arm_en && !wake) state_d = ST_PEND;
            ST_PEND: state_d = wake ? ST_CONN : ST_DISC;
            ST_DISC: begin
                if (reconn_q)  state_d  = ST_CONN;
                else if (wake) reconn_d = 1'b1;
            end
            default: state_d = ST_CONN;
        endcase
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_CONN;
            reconn_q <= 1'b0;
            stp_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            reconn_q <= reconn_d;
            stp_q    <= stp_d;
        end
    end

    // Drive the outputs straight from the registered state.
    always_comb begin
        disc_req      = (state_q == ST_PEND);
        reconn_req    = reconn_q;
        bus_connected = (state_q != ST_DISC);
        stpgnt_active = stp_q;
    end

    a_r1_pend_to_disc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && !wake) |=> state_q == ST_DISC);
    a_r2_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONN && !arm_en) |=> state_q != ST_PEND);
    a_r3_halt_never_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONN && is_halt) |=> state_q != ST_PEND);
    a_r8_reconn_single: assert property (@(posedge clk) disable iff (!rst_n)
        reconn_q |=> (state_q == ST_CONN && !reconn_q));
    a_r9_stay_disc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DISC && !wake && !reconn_q) |=> state_q == ST_DISC);
    a_r10_wake_clears_stp: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !stp_q);
    a_r11_wake_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && wake) |=> state_q == ST_CONN);
endmodule

// File: rtl/spc_disc_top.sv
// Top level: control byte register, special-cycle decoder and disconnect state
// machine. The enable is the stored bit, so a write in the same cycle as a
// stop grant acts only from the next cycle on.
module spc_disc_top
    import spc_disc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_skew_en,
    input  logic              suspend_ind,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              spc_valid,
    input  logic [TYPE_W-1:0] spc_type,
    input  logic              wake,
    output logic              disc_req,
    output logic              reconn_req,
    output logic              bus_connected,
    output logic              stpgnt_active,
    output logic              low_power
);
    logic [CFG_W-1:0] cfg_q;
    logic             is_halt, is_stpgnt;

    spc_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .strap(strap_skew_en), .suspend_ind(suspend_ind),
        .wr(cfg_wr), .wdata(cfg_wdata), .cfg_q(cfg_q)
    );

    spc_decode u_dec (
        .valid(spc_valid), .code(spc_type), .is_halt(is_halt), .is_stpgnt(is_stpgnt)
    );

    spc_disc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .arm_en(cfg_q[EN_BIT]), .is_halt(is_halt),
        .is_stpgnt(is_stpgnt), .wake(wake), .disc_req(disc_req),
        .reconn_req(reconn_req), .bus_connected(bus_connected),
        .stpgnt_active(stpgnt_active)
    );

    // Expose the byte and the combined power-saving flag.
    always_comb begin
        cfg_rdata = cfg_q;
        low_power = stpgnt_active && !bus_connected;
    end

    a_r7_lowpower_follows_disc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_power) |-> !$past(reconn_req));
endmodule

// File: tb/spc_disc_top_tb_top.sv
module spc_disc_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_skew_en = 1'b1;
    logic       suspend_ind = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       spc_valid = 1'b0;
    logic [1:0] spc_type = 2'b00;
    logic       wake = 1'b0;
    logic       disc_req, reconn_req, bus_connected, stpgnt_active, low_power;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench model, written from the requirements.
    logic [7:0] m_cfg = 8'h78;
    int         m_st  = 0;     // 0 connected, 1 pending, 2 disconnected
    logic       m_rc  = 1'b0;
    logic       m_stp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spc_disc_top dut_i (
        .clk(clk), .rst_n(rst_n), .strap_skew_en(strap_skew_en),
        .suspend_ind(suspend_ind), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .spc_valid(spc_valid), .spc_type(spc_type),
        .wake(wake), .disc_req(disc_req), .reconn_req(reconn_req),
        .bus_connected(bus_connected), .stpgnt_active(stpgnt_active),
        .low_power(low_power)
    );

    function automatic logic [7:0] reset_image(input logic strap);
        return {4'b0111, strap, 3'b000};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic r, input logic v, input logic [1:0] t,
                              input logic w, input logic wr, input logic [7:0] wd);
        logic sg;
        logic en;
        sg = v && (t == 2'b10);
        en = m_cfg[7];
        if (!r) begin
            m_cfg = reset_image(strap_skew_en);
            m_st = 0; m_rc = 1'b0; m_stp = 1'b0;
        end else begin
            logic rc_n;
            rc_n = 1'b0;
            case (m_st)
                0: if (sg && en && !w) m_st = 1;
                1: m_st = w ? 0 : 2;
                default: if (m_rc) m_st = 0; else if (w) rc_n = 1'b1;
            endcase
            m_rc = rc_n;
            if (w) m_stp = 1'b0; else if (sg) m_stp = 1'b1;
            if (wr) m_cfg = wd;
        end
    endtask

    // Drive one cycle of inputs, advance the model, and compare every output after the edge.
    task automatic cyc(input logic r, input logic v, input logic [1:0] t, input logic w,
                       input logic wr, input logic [7:0] wd, input logic sus);
        rst_n = r; spc_valid = v; spc_type = t; wake = w;
        cfg_wr = wr; cfg_wdata = wd; suspend_ind = sus;
        model_step(r, v, t, w, wr, wd);
        @(negedge clk);
        check("R5 cfg_rdata", cfg_rdata, m_cfg);
        check("R1 disc_req", {7'd0, disc_req}, {7'd0, m_st == 1});
        check("R8 reconn_req", {7'd0, reconn_req}, {7'd0, m_rc});
        check("R9 bus_connected", {7'd0, bus_connected}, {7'd0, m_st != 2});
        check("R7 stpgnt_active", {7'd0, stpgnt_active}, {7'd0, m_stp});
        check("R7 low_power", {7'd0, low_power}, {7'd0, m_stp && m_st == 2});
    endtask

    task automatic idle();
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        // R4: reset image with strap present, then absent.
        strap_skew_en = 1'b1;
        cyc(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R4 reset strap1", cfg_rdata, 8'h78);
        check("R4 reset connected", {7'd0, bus_connected}, 8'h01);
        strap_skew_en = 1'b0;
        cyc(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R4 reset strap0", cfg_rdata, 8'h70);
        idle();
        // R2: stop grant with enable clear.
        cyc(1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R2 no disc", {7'd0, disc_req}, 8'h00);
        check("R7 stp set w/o enable", {7'd0, stpgnt_active}, 8'h01);
        idle();
        check("R2 still connected", {7'd0, bus_connected}, 8'h01);
        cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 8'h00, 1'b0);
        // R3: halt and unknown codes with enable set.
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 8'hF0, 1'b0);
        cyc(1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R3 halt no disc", {7'd0, disc_req}, 8'h00);
        cyc(1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R3 code00 no disc", {7'd0, disc_req}, 8'h00);
        cyc(1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R3 code11 no disc", {7'd0, disc_req}, 8'h00);
        // R1 / R7: full disconnect.
        cyc(1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R1 disc_req", {7'd0, disc_req}, 8'h01);
        idle();
        check("R1 disconnected", {7'd0, bus_connected}, 8'h00);
        check("R7 low_power", {7'd0, low_power}, 8'h01);
        // R6: suspend keeps everything.
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1);
        check("R6 cfg kept", cfg_rdata, 8'hF0);
        check("R6 still disc", {7'd0, bus_connected}, 8'h00);
        // R9: clear the enable while disconnected.
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 8'h70, 1'b0);
        idle(); idle();
        check("R9 no self reconnect", {7'd0, bus_connected}, 8'h00);
        // R8: wake reconnects after one request cycle.
        cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R8 reconn high", {7'd0, reconn_req}, 8'h01);
        check("R8 still disc", {7'd0, bus_connected}, 8'h00);
        idle();
        check("R8 reconnected", {7'd0, bus_connected}, 8'h01);
        check("R8 reconn low", {7'd0, reconn_req}, 8'h00);
        // R10: wake and stop grant together.
        cyc(1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 8'hF5, 1'b0);
        cyc(1'b1, 1'b1, 2'b10, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R10 no disc", {7'd0, disc_req}, 8'h00);
        check("R10 no stp", {7'd0, stpgnt_active}, 8'h00);
        // R11: wake in the pending cycle.
        cyc(1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 8'h00, 1'b0);
        cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 8'h00, 1'b0);
        check("R11 cancelled", {7'd0, disc_req}, 8'h00);
        check("R11 connected", {7'd0, bus_connected}, 8'h01);
        // R12: write and stop grant together use the old enable.
        cyc(1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 8'h00, 1'b0);
        check("R12 old enable set", {7'd0, disc_req}, 8'h01);
        idle();
        cyc(1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 8'h00, 1'b0);
        idle();
        cyc(1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 8'h80, 1'b0);
        check("R12 old enable clear", {7'd0, disc_req}, 8'h00);
        // Random traffic with frequent collisions.
        for (int i = 0; i < 4000; i++) begin
            logic v, w, wr, sus;
            logic [1:0] t;
            logic [7:0] wd;
            v   = ($urandom % 3) == 0;
            t   = 2'($urandom);
            w   = ($urandom % 7) == 0;
            wr  = ($urandom % 9) == 0;
            wd  = 8'($urandom);
            sus = ($urandom % 5) == 0;
            cyc(($urandom % 300) != 0, v, t, w, wr, wd, sus);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule